// File: doc/BRIEF.md
# Integer Result Status Flag Unit

This block sits beside an integer ALU and keeps the status that ALU results produce. It holds a 4-bit condition field, a carry flag, an overflow flag and a sticky summary-overflow flag. On every clock edge it looks at the operation class presented with the current result and updates only the flags that class is allowed to touch. Record and overflow-enable controls widen or narrow that set. A wide/narrow mode bit chooses whether the zero test, the overflow test and the carry test work on the full 64-bit datapath or on its low 32 bits.

A software write port loads the carry, overflow and summary-overflow flags directly. Writing zeros clears them, and this is the only way the sticky summary-overflow bit ever returns to zero. All outputs come straight from registers, so a result presented before a rising edge is reflected in the outputs after that edge.

Top module: `int_status_flags`

## Requirements
- R1: Synchronous active-low reset clears the condition field, carry, overflow and summary overflow to 0.
- R2: With `rec_en` set and a recording class (carry-add 1, arith 2, logic 3, shift-right-algebraic 4, count-leading-zeros 5), the condition field becomes {LT, GT, EQ, SO}. LT is bit 3, GT is bit 2, EQ is bit 1, SO is bit 0. LT, GT and EQ come from a signed comparison of the result with zero. SO is the summary-overflow value after the update. With `rec_en` clear, the condition field is unchanged.
- R3: With `mode_wide`=1 all 64 result bits take part in the zero test and bit 63 is the sign. With `mode_wide`=0 only bits 31:0 take part and bit 31 is the sign; bits 63:32 have no effect.
- R4: Logic-class results (class 3) with `rec_en` set are still compared as signed numbers.
- R5: For classes 1 and 2 with `ovf_en` set, overflow becomes carry-into-MSB XOR carry-out-of-MSB. Index 1 of the carry vectors is bit 63 (wide mode) and index 0 is bit 31 (narrow mode). When that XOR is 0, overflow is cleared and summary overflow keeps its value. With `ovf_en` clear, overflow is unchanged.
- R6: Summary overflow is set whenever overflow is set by an ALU update, and it stays set across all later ALU updates.
- R7: Class 1 (carrying add/subtract) loads carry from `carry_out_msb` at the mode's index.
- R8: Class 4 sets carry when the shift operand is negative (bit 63 wide, bit 31 narrow) and at least one 1 bit lies below the shift amount in the mode's active bits. Otherwise it clears carry.
- R9: Class 5 with `rec_en` set always gives LT=0, whatever the sign of the result.
- R10: Classes 0 (plain add, add-immediate, subtract-from), 6 and 7 change no flag, even with `rec_en` or `ovf_en` set.
- R11: When `sw_we` is set, carry, overflow and summary overflow load from `sw_wdata[0]`, `sw_wdata[1]` and `sw_wdata[2]`. Any ALU update in that cycle is dropped, and the condition field is unchanged.
- R12: Classes 3, 4 and 5 never change overflow or summary overflow, even with `ovf_en` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_class | input | 3 | Operation class of the current result |
| rec_en | input | 1 | Record the zero comparison into the condition field |
| ovf_en | input | 1 | Enable overflow detection |
| mode_wide | input | 1 | 1: 64-bit tests, 0: 32-bit tests |
| alu_result | input | 64 | ALU result to compare with zero |
| carry_into_msb | input | 2 | Carry into the MSB; [0] bit 31, [1] bit 63 |
| carry_out_msb | input | 2 | Carry out of the MSB; [0] bit 31, [1] bit 63 |
| shra_operand | input | 64 | Source operand of a shift-right-algebraic |
| shra_amount | input | 6 | Shift amount of a shift-right-algebraic |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 3 | Software value {SO, OV, CA} |
| cond_field | output | 4 | Registered {LT, GT, EQ, SO} |
| carry_flag | output | 1 | Registered carry |
| ovf_flag | output | 1 | Registered overflow |
| sum_ovf_flag | output | 1 | Registered sticky summary overflow |

## Verification
The hardest situation to reach is a sticky summary-overflow bit that is still observable. Once any overflow occurs it never clears by itself, so a naive sweep would run almost entirely with SO stuck at 1. The bench therefore inserts software writes at a fixed interval, which clear or set the flags from a rotating pattern. These writes carry live ALU stimulus in the same cycle, so they also test write priority. The sweep crosses every class with both modes, both controls, all four carry-into/carry-out pairings and results chosen around the 32-bit and 64-bit sign boundaries. A second sweep drives every shift amount against operands whose ones sit just above or below each boundary.

// File: rtl/flag_unit_pkg.sv
// Package: shared types for the integer status flag unit.
// Assumes: operation class codes are fixed by the issuing ALU decoder.
package flag_unit_pkg;

    typedef enum logic [2:0] {
        OPC_PASS      = 3'd0,  // plain add / add-immediate / subtract-from
        OPC_ADD_CARRY = 3'd1,  // carrying add / subtract
        OPC_ARITH     = 3'd2,  // add / subtract / negate without carry
        OPC_LOGIC     = 3'd3,  // logical and rotate
        OPC_SHRA      = 3'd4,  // shift right algebraic
        OPC_CLZ       = 3'd5,  // count leading zeros
        OPC_RSV6      = 3'd6,
        OPC_RSV7      = 3'd7
    } op_class_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    // True for classes whose result may be recorded
    function automatic logic class_records(op_class_e c);
        return (c == OPC_ADD_CARRY) || (c == OPC_ARITH) || (c == OPC_LOGIC) ||
               (c == OPC_SHRA) || (c == OPC_CLZ);
    endfunction

    // True for classes that may detect overflow
    function automatic logic class_ovf(op_class_e c);
        return (c == OPC_ADD_CARRY) || (c == OPC_ARITH);
    endfunction

endpackage

// File: rtl/flag_zero_cmp.sv
// Module: signed comparison of a result against zero.
// Does: reports less-than, greater-than and equal for either the full
//       width or the low half of the value, chosen by mode_wide.
// Assumes: W is even; the narrow view uses bit W/2-1 as its sign.
module flag_zero_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] value,
    input  logic         mode_wide,
    output logic         is_neg,
    output logic         is_pos,
    output logic         is_zero
);
    localparam int HALF = W / 2;

    logic low_zero;
    logic high_zero;
    logic sign_bit;

    // Purpose: reduce each half to a zero indication and pick the sign
    always_comb begin
        low_zero  = ~|value[HALF-1:0];
        high_zero = ~|value[W-1:HALF];
        sign_bit  = mode_wide ? value[W-1] : value[HALF-1];
        is_zero   = low_zero & (high_zero | ~mode_wide);
        is_neg    = sign_bit;
        is_pos    = ~sign_bit & ~is_zero;
    end
endmodule

// File: rtl/flag_shra_carry.sv
// Module: carry of a shift-right-algebraic.
// Does: flags a negative operand that loses at least one 1 bit.
// Assumes: amounts at or above the narrow width in narrow mode shift out
//          every active bit.
module flag_shra_carry #(
    parameter int W = 64
) (
    input  logic [W-1:0]         operand,
    input  logic [$clog2(W)-1:0] amount,
    input  logic                 mode_wide,
    output logic                 carry
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

    logic [W-1:0] lost_mask;
    logic         sign_bit;

    // Purpose: build the mask of shifted-out positions and test it
    always_comb begin
        lost_mask = ~({W{1'b1}} << amount);
        if (!mode_wide) begin
            lost_mask = lost_mask & LOW_MASK;
        end
        sign_bit = mode_wide ? operand[W-1] : operand[HALF-1];
        carry    = sign_bit & (|(operand & lost_mask));
    end
endmodule

// File: rtl/flag_ovf_detect.sv
// Module: overflow and carry selection at the active MSB.
// Does: picks the carry pair of the active width and compares it.
// Assumes: index 0 of each carry vector is the narrow MSB, index 1 the wide.
module flag_ovf_detect #(
    parameter int NMODES = 2
) (
    input  logic [NMODES-1:0] cin_msb,
    input  logic [NMODES-1:0] cout_msb,
    input  logic              mode_wide,
    output logic              ovf,
    output logic              carry
);
    logic [NMODES-1:0] mismatch;

    // Purpose: one mismatch detector per supported width
    for (genvar g = 0; g < NMODES; g++) begin : g_mode
        assign mismatch[g] = cin_msb[g] ^ cout_msb[g];
    end

    // Purpose: select the active width's results
    always_comb begin
        ovf   = mismatch[mode_wide];
        carry = cout_msb[mode_wide];
    end
endmodule

// File: rtl/int_status_flags.sv
// Module: integer result status flag unit (top).
// Does: derives and holds the condition field, carry, overflow and sticky
//       summary overflow for each ALU result; a software write port loads
//       the three exception flags and wins over an ALU update.
// Assumes: one result per cycle; op_class codes as in flag_unit_pkg.
module int_status_flags
    import flag_unit_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              op_class,
    input  logic                    rec_en,
    input  logic                    ovf_en,
    input  logic                    mode_wide,
    input  logic [XLEN-1:0]         alu_result,
    input  logic [1:0]              carry_into_msb,
    input  logic [1:0]              carry_out_msb,
    input  logic [XLEN-1:0]         shra_operand,
    input  logic [$clog2(XLEN)-1:0] shra_amount,
    input  logic                    sw_we,
    input  logic [2:0]              sw_wdata,
    output logic [3:0]              cond_field,
    output logic                    carry_flag,
    output logic                    ovf_flag,
    output logic                    sum_ovf_flag
);
    localparam int NMODES = 2;

    op_class_e op_e;
    cond_t     cr_q, cr_d;
    logic      ca_q, ca_d;
    logic      ov_q, ov_d;
    logic      so_q, so_d;
    logic      zc_neg, zc_pos, zc_zero;
    logic      shra_ca;
    logic      ovf_raw, add_ca;

    assign op_e = op_class_e'(op_class);

    flag_zero_cmp #(.W(XLEN)) u_zero (
        .value     (alu_result),
        .mode_wide (mode_wide),
        .is_neg    (zc_neg),
        .is_pos    (zc_pos),
        .is_zero   (zc_zero)
    );

    flag_shra_carry #(.W(XLEN)) u_shra (
        .operand   (shra_operand),
        .amount    (shra_amount),
        .mode_wide (mode_wide),
        .carry     (shra_ca)
    );

    flag_ovf_detect #(.NMODES(NMODES)) u_ovf (
        .cin_msb   (carry_into_msb),
        .cout_msb  (carry_out_msb),
        .mode_wide (mode_wide),
        .ovf       (ovf_raw),
        .carry     (add_ca)
    );

    // Purpose: next-state selection; software write has priority
    always_comb begin
        cr_d = cr_q;
        ca_d = ca_q;
        ov_d = ov_q;
        so_d = so_q;
        if (sw_we) begin
            ca_d = sw_wdata[0];
            ov_d = sw_wdata[1];
            so_d = sw_wdata[2];
        end else begin
            if (ovf_en && class_ovf(op_e)) begin
                ov_d = ovf_raw;
                so_d = so_q | ovf_raw;
            end
            if (op_e == OPC_ADD_CARRY) begin
                ca_d = add_ca;
            end else if (op_e == OPC_SHRA) begin
                ca_d = shra_ca;
            end
            if (rec_en && class_records(op_e)) begin
                cr_d.lt = zc_neg & (op_e != OPC_CLZ);
                cr_d.gt = zc_pos;
                cr_d.eq = zc_zero;
                cr_d.so = so_d;
            end
        end
    end

    // Purpose: flag registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
            ca_q <= 1'b0;
            ov_q <= 1'b0;
            so_q <= 1'b0;
        end else begin
            cr_q <= cr_d;
            ca_q <= ca_d;
            ov_q <= ov_d;
            so_q <= so_d;
        end
    end

    assign cond_field   = cr_q;
    assign carry_flag   = ca_q;
    assign ovf_flag     = ov_q;
    assign sum_ovf_flag = so_q;

    AST_PASS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && (op_class == 3'd0 || op_class == 3'd6 || op_class == 3'd7))
        |=> $stable({cond_field, carry_flag, ovf_flag, sum_ovf_flag})); // R10

    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_ovf_flag && !sw_we) |=> sum_ovf_flag); // R6

    AST_OVERFLOW_SETS_SO: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && ovf_en && (op_class == 3'd1 || op_class == 3'd2) &&
         (carry_into_msb[mode_wide] != carry_out_msb[mode_wide]))
        |=> (ovf_flag && sum_ovf_flag)); // R5

    AST_OE_OFF_KEEPS_OV: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !ovf_en) |=> $stable(ovf_flag)); // R5

    AST_NON_ARITH_KEEPS_OV: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && (op_class == 3'd3 || op_class == 3'd4 || op_class == 3'd5))
        |=> ($stable(ovf_flag) && $stable(sum_ovf_flag))); // R12

    AST_CLZ_NO_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && rec_en && op_class == 3'd5) |=> !cond_field[3]); // R9

    AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && rec_en && op_class >= 3'd1 && op_class <= 3'd4)
        |=> ($countones(cond_field[3:1]) == 1)); // R2

    AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (({sum_ovf_flag, ovf_flag, carry_flag} == $past(sw_wdata)) &&
                   $stable(cond_field))); // R11

endmodule

// File: tb/sim_int_status_flags.sv
// Bench: sweeps classes, modes, controls, carries and boundary results and
// checks every flag against an arithmetic reference model.
module sim_int_status_flags;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_class;
    logic        rec_en, ovf_en, mode_wide;
    logic [63:0] alu_result;
    logic [1:0]  carry_into_msb, carry_out_msb;
    logic [63:0] shra_operand;
    logic [5:0]  shra_amount;
    logic        sw_we;
    logic [2:0]  sw_wdata;
    logic [3:0]  cond_field;
    logic        carry_flag, ovf_flag, sum_ovf_flag;

    logic [3:0] e_cr;
    logic       e_ca, e_ov, e_so;
    int         n_chk = 0;
    int         n_fail = 0;
    int         step_no = 0;

    always #2 clk = ~clk;

    int_status_flags #(.XLEN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .rec_en(rec_en),
        .ovf_en(ovf_en), .mode_wide(mode_wide), .alu_result(alu_result),
        .carry_into_msb(carry_into_msb), .carry_out_msb(carry_out_msb),
        .shra_operand(shra_operand), .shra_amount(shra_amount),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .cond_field(cond_field),
        .carry_flag(carry_flag), .ovf_flag(ovf_flag), .sum_ovf_flag(sum_ovf_flag)
    );

    function automatic logic [63:0] pattern(int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h0000_0000_8000_0000;
            5: return 64'hFFFF_FFFF_0000_0000;
            6: return 64'h7FFF_FFFF_0000_0001;
            7: return 64'h8000_0000_0000_0010;
            default: return 64'h0000_0000_8000_0100;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] c, logic sw);
        if (sw) return "R11";
        case (c)
            3'd1: return "R7";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R8";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Reference model: advance the expected flags by one cycle
    task automatic model_step();
        int  m;
        logic signed [63:0] sv;
        logic lost, sgn, ovf;
        m = mode_wide ? 1 : 0;
        if (sw_we) begin
            {e_so, e_ov, e_ca} = sw_wdata;            // R11
            return;
        end
        if (op_class == 3'd1 || op_class == 3'd2) begin
            if (ovf_en) begin
                ovf  = carry_into_msb[m] ^ carry_out_msb[m];
                e_ov = ovf;
                if (ovf) e_so = 1'b1;                 // R6
            end
            if (op_class == 3'd1) e_ca = carry_out_msb[m];
        end
        if (op_class == 3'd4) begin
            sgn  = mode_wide ? shra_operand[63] : shra_operand[31];
            lost = 1'b0;
            for (int i = 0; i < (mode_wide ? 64 : 32); i++)
                if (i < int'(shra_amount) && shra_operand[i]) lost = 1'b1;
            e_ca = sgn & lost;
        end
        if (rec_en && op_class >= 3'd1 && op_class <= 3'd5) begin
            sv = mode_wide ? $signed(alu_result) : 64'($signed(alu_result[31:0]));
            e_cr = {(sv < 0) && (op_class != 3'd5), sv > 0, sv == 0, e_so};
        end
    endtask

    task automatic check(string tag);
        logic [6:0] got, exp;
        got = {cond_field, carry_flag, ovf_flag, sum_ovf_flag};
        exp = {e_cr, e_ca, e_ov, e_so};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s step %0d: got %b expected %b", tag, step_no, got, exp);
        end
    endtask

    task automatic step(string tag);
        @(negedge clk);
        model_step();
        @(negedge clk);
        step_no++;
        check(tag);
    endtask

    task automatic drive(logic [2:0] c, logic r, logic o, logic m, logic [63:0] res,
                         logic [1:0] ci, logic [1:0] co);
        op_class = c; rec_en = r; ovf_en = o; mode_wide = m; alu_result = res;
        carry_into_msb = ci; carry_out_msb = co;
    endtask

    initial begin
        rst_n = 1'b0; sw_we = 1'b0; sw_wdata = '0;
        shra_operand = '0; shra_amount = '0;
        drive(3'd2, 1'b1, 1'b1, 1'b1, 64'h5, 2'b11, 2'b00);
        repeat (3) @(negedge clk);
        e_cr = '0; e_ca = 0; e_ov = 0; e_so = 0;
        check("R1");                                   // R1 reset state
        rst_n = 1'b1;
        drive(3'd0, 0, 0, 1, 0, 0, 0);

        // R2 / R4: positive logic result, recorded
        drive(3'd3, 1, 0, 1, 64'h5, 0, 0); step("R2");
        // R3: upper bits ignored in narrow mode -> EQ
        drive(3'd3, 1, 0, 0, 64'hFFFF_FFFF_0000_0000, 0, 0); step("R3");
        // R3: bit 31 is the narrow sign -> LT
        drive(3'd3, 1, 0, 0, 64'h0000_0000_8000_0000, 0, 0); step("R3");
        // R6: overflow then a clean overflow-enabled op keeps SO
        drive(3'd2, 1, 1, 1, 64'h1, 2'b10, 2'b00); step("R6");
        drive(3'd2, 1, 1, 1, 64'h1, 2'b00, 2'b00); step("R6");
        // R12: logic with overflow enable leaves OV and SO
        drive(3'd3, 0, 1, 1, 64'h1, 2'b11, 2'b00); step("R12");
        // R11: write zeros with live ALU update
        sw_we = 1; sw_wdata = 3'b000;
        drive(3'd2, 1, 1, 1, 64'h0, 2'b10, 2'b00); step("R11");
        sw_we = 0;

        // Main sweep: class x mode x record x enable x carries x results
        for (int c = 0; c < 8; c++)
            for (int m = 0; m < 2; m++)
                for (int ro = 0; ro < 4; ro++)
                    for (int cc = 0; cc < 4; cc++)
                        for (int p = 0; p < 9; p++) begin
                            logic [1:0] ci, co;
                            ci = {cc[0], cc[0]};
                            co = {cc[1], cc[1] ^ (p == 4)};
                            drive(3'(c), ro[0], ro[1], m[0], pattern(p), ci, co);
                            shra_operand = pattern(8 - p);
                            shra_amount  = 6'((p * 7 + c * 3) % 64);
                            sw_we = ((step_no % 37) == 36);
                            sw_wdata = 3'(step_no / 37);
                            step(tag_of(3'(c), sw_we));
                            sw_we = 0;
                        end

        // Shift-right-algebraic carry sweep (R8) over every amount
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 64; a++)
                for (int p = 0; p < 9; p++) begin
                    drive(3'd4, a[0], 0, m[0], pattern(p), 0, 0);
                    shra_operand = pattern(p) | (p == 2 ? 64'h0 : 64'h0);
                    shra_amount  = 6'(a);
                    step("R8");
                end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule